// File: doc/BRIEF.md
# Two-Plane Cache Program Sequencer for NAND Flash

This block is a host-side controller for a NAND flash device on an 8-bit command/address/data bus. It writes page pairs, one page in each of two planes, using cache programming. For each accepted request it sends the bytes in this order:

- the first-plane setup command, the first-plane address and the first-plane data;
- the plane-switch command;
- the second-plane setup command, the second-plane address and the second-plane data;
- a confirm command. The confirm is either the cache confirm, which lets further page pairs follow, or the final confirm, which ends the sequence.

After each busy-causing command the block waits for the device. It either watches the ready/busy pin and then reads the status byte once, or it polls the combined two-plane status repeatedly. It then turns the status bits into pass/fail results for the page pair that has just been confirmed and for the page pair before it.

The host offers a request that holds two block numbers, a page number and a "last" flag. The page data comes byte by byte through a take strobe: the byte present on `wr_data` in a cycle where `wr_take` is high is placed on the bus in that cycle. A configuration input selects the second-plane setup opcode. A second input selects pin waiting or status polling. A third sets a timeout that bounds every wait.

Top module: `nand_mpc_seq`

## Requirements
- R1: Bus encoding and byte order. A bus byte is transferred in every cycle with `nf_we` high. `nf_cle` marks a command byte and `nf_ale` marks an address byte. The order for one page pair is:
  - 80h;
  - the address of block A;
  - NBYTES data bytes;
  - 11h;
  - the second setup opcode;
  - the address of block B;
  - NBYTES data bytes;
  - the confirm opcode.
  Each address is the value {block, page}, sent least significant byte first in ceil((BLK_W+PAGE_W)/8) bytes.
- R2: The second-plane setup opcode is 81h when `cfg_onfi` is 0 and 80h when `cfg_onfi` is 1.
- R3: A request with `req_last`=0 ends with confirm 15h, after which the next request continues the chain. A request with `req_last`=1 ends with 10h and returns the block to idle.
- R4: A request is accepted only when `req_blk_a` is even and `req_blk_b` equals `req_blk_a`+1. Any other request is consumed with a one-cycle `err_pair` pulse, produces no bus cycle, and leaves the idle or chain state unchanged.
- R5: Waiting happens after 11h, 15h and 10h.
  - When `cfg_poll`=0, the block waits for `nf_rb` high and then issues one 70h command and one read cycle (`nf_re`).
  - When `cfg_poll`=1, it repeats the 70h command and read until the wait condition holds.
  - The condition after 11h or 15h is status bit 6 set. The condition after 10h is status bits 6 and 5 both set.
- R6: No command other than 70h, and no address or data byte, is issued while the device is busy.
- R7: After 15h the block gives a one-cycle `done_valid` with these fields:
  - `done_final`=0;
  - `done_prev_vld`=1 unless the pair is the first of its chain;
  - `done_prev_fail` equal to status bit 1 when `done_prev_vld` is 1, otherwise 0;
  - `done_cur_fail`=0.
- R8: After 10h the block gives a one-cycle `done_valid` with `done_final`=1, `done_cur_fail` equal to status bit 0, and `done_prev_fail` and `done_prev_vld` as in R7.
- R9: If a wait lasts more than `cfg_timeout` cycles, the block pulses `err_timeout`, abandons the chain and returns to idle. The pulse comes between `cfg_timeout` and `cfg_timeout`+4 cycles after the busy-causing command.
- R10: Page data is taken one byte per cycle through `wr_take`, and the byte is driven as a data cycle (`nf_cle`=`nf_ale`=0) in the same cycle.
- R11: After reset the block is idle with `req_ready`=1, no bus cycle and no result or error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_onfi | input | 1 | 1: second setup opcode is 80h; 0: 81h |
| cfg_poll | input | 1 | 1: poll status; 0: wait for ready/busy pin |
| cfg_timeout | input | TMO_W | Maximum wait length in cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (idle or chain state) |
| req_last | input | 1 | Request ends the sequence |
| req_blk_a | input | BLK_W | First-plane block |
| req_blk_b | input | BLK_W | Second-plane block |
| req_page | input | PAGE_W | Page within both blocks |
| wr_take | output | 1 | Data byte consumed this cycle |
| wr_data | input | 8 | Current data byte |
| nf_cle | output | 1 | Command byte marker |
| nf_ale | output | 1 | Address byte marker |
| nf_we | output | 1 | Byte written this cycle |
| nf_re | output | 1 | Status byte read this cycle |
| nf_dq_out | output | 8 | Bus byte driven |
| nf_dq_in | input | 8 | Bus byte returned by the device |
| nf_rb | input | 1 | Device ready (1) or busy (0) |
| done_valid | output | 1 | Result pulse |
| done_final | output | 1 | Result belongs to a final confirm |
| done_prev_vld | output | 1 | A previous pair exists in the chain |
| done_prev_fail | output | 1 | Previous pair failed |
| done_cur_fail | output | 1 | Current pair failed (final confirm only) |
| err_pair | output | 1 | Request rejected for unpaired blocks |
| err_timeout | output | 1 | Wait abandoned |

## Verification
The hardest situation to reach is a result that mixes two page pairs. It needs a chain in which the previous-pair bit and the current-pair bit differ, and these arrive through the status of different confirms. The bench sweeps every pass/fail pattern over chains of one to three pairs, for both opcode variants and both wait methods, against a device model that raises the two bits from the pattern. A stuck-busy model produces the timeout case. A rejected request is also injected between two chained pairs, to show that the chain survives the rejection.

// File: rtl/nmcp_pkg.sv
// Shared opcodes, state and wait-kind types for the two-plane cache program sequencer.
package nmcp_pkg;
    localparam logic [7:0] OP_SETUP   = 8'h80;
    localparam logic [7:0] OP_SETUP2N = 8'h81;
    localparam logic [7:0] OP_SWITCH  = 8'h11;
    localparam logic [7:0] OP_CACHE   = 8'h15;
    localparam logic [7:0] OP_FINAL   = 8'h10;
    localparam logic [7:0] OP_STATUS  = 8'h70;

    typedef enum logic [3:0] {
        S_IDLE, S_SU1, S_AD1, S_DT1, S_SW, S_SU2, S_AD2, S_DT2,
        S_CF, S_WPIN, S_SCMD, S_SRD, S_CHAIN
    } seq_st_t;

    typedef enum logic [1:0] { K_SW, K_CACHE, K_FINAL } wkind_t;
endpackage

// File: rtl/nmcp_pair_chk.sv
// Block pairing check.
// Assumes the plane is selected by the block number's least significant bit,
// so a valid pair is an even block A and B = A + 1.
module nmcp_pair_chk #(
    parameter int BLK_W = 6
) (
    input  logic [BLK_W-1:0] blk_a,
    input  logic [BLK_W-1:0] blk_b,
    output logic             pair_ok
);
    // Pair is valid when A is even and B is its odd neighbour.
    always_comb pair_ok = !blk_a[0] && (blk_b == (blk_a | BLK_W'(1)));
endmodule

// File: rtl/nmcp_wait_tmr.sv
// Busy-wait timeout counter.
// Cleared when a wait begins; counts each cycle while run is high;
// expired is raised once the count has reached the limit.
// Assumes clr and run are never high together.
module nmcp_wait_tmr #(
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    // Count wait cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (run && cnt != limit)
            cnt <= cnt + TMO_W'(1);
    end

    // Expiry is only meaningful while a wait is running.
    always_comb expired = run && (cnt == limit);
endmodule

// File: rtl/nmcp_stat_dec.sv
// Status decoder.
// Turns the four meaningful status bits {bit6, bit5, bit1, bit0} into the
// wait condition and the per-pair fail flags for the current wait kind.
module nmcp_stat_dec
    import nmcp_pkg::*;
(
    input  wkind_t     kind,
    input  logic [3:0] sts,
    input  logic       prev_vld,
    output logic       cond_ok,
    output logic       prev_fail,
    output logic       cur_fail
);
    // A final confirm also needs the array idle; the other waits need only cache ready.
    always_comb begin
        cond_ok   = (kind == K_FINAL) ? (sts[3] && sts[2]) : sts[3];
        prev_fail = prev_vld && sts[1];
        cur_fail  = (kind == K_FINAL) && sts[0];
    end
endmodule

// File: rtl/nand_mpc_seq.sv
// Two-plane cache program sequencer (top level).
// Drives a NAND 8-bit bus, one byte per cycle, to program page pairs
// through the cache path, and decodes the combined status into results.
// Assumes the device returns status combinationally in a read cycle, and
// that wr_data is valid whenever wr_take is high.
module nand_mpc_seq
    import nmcp_pkg::*;
#(
    parameter int BLK_W  = 6,
    parameter int PAGE_W = 6,
    parameter int NBYTES = 4,
    parameter int TMO_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_onfi,
    input  logic              cfg_poll,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_last,
    input  logic [BLK_W-1:0]  req_blk_a,
    input  logic [BLK_W-1:0]  req_blk_b,
    input  logic [PAGE_W-1:0] req_page,
    output logic              wr_take,
    input  logic [7:0]        wr_data,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_we,
    output logic              nf_re,
    output logic [7:0]        nf_dq_out,
    input  logic [7:0]        nf_dq_in,
    input  logic              nf_rb,
    output logic              done_valid,
    output logic              done_final,
    output logic              done_prev_vld,
    output logic              done_prev_fail,
    output logic              done_cur_fail,
    output logic              err_pair,
    output logic              err_timeout
);
    localparam int AW    = BLK_W + PAGE_W;
    localparam int NADDR = (AW + 7) / 8;
    localparam int ASH_W = NADDR * 8;
    localparam int NMAX  = (NBYTES > NADDR) ? NBYTES : NADDR;
    localparam int IW    = $clog2(NMAX) + 1;

    seq_st_t           st;
    wkind_t            kind_q;
    logic [IW-1:0]     idx;
    logic [ASH_W-1:0]  ash;
    logic [BLK_W-1:0]  blk_b_q;
    logic [PAGE_W-1:0] pg_q;
    logic              last_q;
    logic              prev_vld_q;
    logic              pair_ok;
    logic              tmo;
    logic              in_wait;
    logic              cond_ok;
    logic              dec_prev_fail;
    logic              dec_cur_fail;
    logic              unused_sts;
    seq_st_t           wait_entry;

    assign unused_sts = ^{nf_dq_in[7], nf_dq_in[4:2]};

    nmcp_pair_chk #(.BLK_W(BLK_W)) pair_i (
        .blk_a   (req_blk_a),
        .blk_b   (req_blk_b),
        .pair_ok (pair_ok)
    );

    nmcp_wait_tmr #(.TMO_W(TMO_W)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (st == S_SW || st == S_CF),
        .run     (in_wait),
        .limit   (cfg_timeout),
        .expired (tmo)
    );

    nmcp_stat_dec dec_i (
        .kind      (kind_q),
        .sts       ({nf_dq_in[6], nf_dq_in[5], nf_dq_in[1], nf_dq_in[0]}),
        .prev_vld  (prev_vld_q),
        .cond_ok   (cond_ok),
        .prev_fail (dec_prev_fail),
        .cur_fail  (dec_cur_fail)
    );

    // Wait-state membership and the entry state picked by the wait method.
    always_comb begin
        in_wait    = (st == S_WPIN) || (st == S_SCMD) || (st == S_SRD);
        wait_entry = cfg_poll ? S_SCMD : S_WPIN;
        req_ready  = (st == S_IDLE) || (st == S_CHAIN);
    end

    // Bus drive: every output is decoded from the current state.
    always_comb begin
        nf_cle = 1'b0; nf_ale = 1'b0; nf_we = 1'b0; nf_re = 1'b0;
        nf_dq_out = 8'h00; wr_take = 1'b0;
        unique case (st)
            S_SU1:  begin nf_cle = 1'b1; nf_we = 1'b1; nf_dq_out = OP_SETUP; end
            S_SW:   begin nf_cle = 1'b1; nf_we = 1'b1; nf_dq_out = OP_SWITCH; end
            S_SU2:  begin nf_cle = 1'b1; nf_we = 1'b1; nf_dq_out = cfg_onfi ? OP_SETUP : OP_SETUP2N; end
            S_CF:   begin nf_cle = 1'b1; nf_we = 1'b1; nf_dq_out = last_q ? OP_FINAL : OP_CACHE; end
            S_SCMD: begin nf_cle = 1'b1; nf_we = 1'b1; nf_dq_out = OP_STATUS; end
            S_AD1, S_AD2: begin nf_ale = 1'b1; nf_we = 1'b1; nf_dq_out = ash[7:0]; end
            S_DT1, S_DT2: begin nf_we = 1'b1; wr_take = 1'b1; nf_dq_out = wr_data; end
            S_SRD:  nf_re = 1'b1;
            default: ;
        endcase
    end

    // Sequencer: command ordering, byte counting, waits and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; kind_q <= K_SW; idx <= '0; ash <= '0;
            blk_b_q <= '0; pg_q <= '0; last_q <= 1'b0; prev_vld_q <= 1'b0;
            done_valid <= 1'b0; done_final <= 1'b0; done_prev_vld <= 1'b0;
            done_prev_fail <= 1'b0; done_cur_fail <= 1'b0;
            err_pair <= 1'b0; err_timeout <= 1'b0;
        end else begin
            done_valid  <= 1'b0;
            err_pair    <= 1'b0;
            err_timeout <= 1'b0;
            unique case (st)
                S_IDLE, S_CHAIN: begin
                    if (req_valid) begin
                        if (pair_ok) begin
                            ash        <= ASH_W'({req_blk_a, req_page});
                            blk_b_q    <= req_blk_b;
                            pg_q       <= req_page;
                            last_q     <= req_last;
                            prev_vld_q <= (st == S_CHAIN);
                            idx        <= '0;
                            st         <= S_SU1;
                        end else begin
                            err_pair <= 1'b1;
                        end
                    end
                end
                S_SU1: st <= S_AD1;
                S_SU2: begin
                    ash <= ASH_W'({blk_b_q, pg_q});
                    st  <= S_AD2;
                end
                S_AD1, S_AD2: begin
                    ash <= ash >> 8;
                    if (idx == IW'(NADDR - 1)) begin
                        idx <= '0;
                        st  <= (st == S_AD1) ? S_DT1 : S_DT2;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                S_DT1, S_DT2: begin
                    if (idx == IW'(NBYTES - 1)) begin
                        idx <= '0;
                        st  <= (st == S_DT1) ? S_SW : S_CF;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                S_SW: begin
                    kind_q <= K_SW;
                    st     <= wait_entry;
                end
                S_CF: begin
                    kind_q <= last_q ? K_FINAL : K_CACHE;
                    st     <= wait_entry;
                end
                S_WPIN: begin
                    if (tmo) begin err_timeout <= 1'b1; st <= S_IDLE; end
                    else if (nf_rb) st <= S_SCMD;
                end
                S_SCMD: begin
                    if (tmo) begin err_timeout <= 1'b1; st <= S_IDLE; end
                    else st <= S_SRD;
                end
                S_SRD: begin
                    if (tmo) begin
                        err_timeout <= 1'b1; st <= S_IDLE;
                    end else if (!cond_ok) begin
                        st <= S_SCMD;
                    end else if (kind_q == K_SW) begin
                        st <= S_SU2;
                    end else begin
                        done_valid     <= 1'b1;
                        done_final     <= (kind_q == K_FINAL);
                        done_prev_vld  <= prev_vld_q;
                        done_prev_fail <= dec_prev_fail;
                        done_cur_fail  <= dec_cur_fail;
                        st <= (kind_q == K_FINAL) ? S_IDLE : S_CHAIN;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R4: a rejected request leaves the bus quiet.
    p_reject_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_pair |-> !nf_we);
    // R10: a taken data byte is a plain data cycle on the bus.
    p_take_on_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (nf_we && !nf_cle && !nf_ale));
    // R7: every result comes from a status read one cycle earlier.
    p_done_from_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(nf_re));
    // R8: a final result leaves the block idle.
    p_final_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_final) |-> (req_ready && !nf_we));
    // R9: a timeout returns to idle without a result.
    p_timeout_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> (req_ready && !done_valid));
    // R6: the second setup follows a successful status read.
    p_setup2_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SU2) |-> $past(st == S_SRD));
    // R5: in pin mode, ready leads straight to one status command.
    p_pin_to_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WPIN && nf_rb && !tmo) |=> (nf_cle && nf_dq_out == OP_STATUS));
endmodule

// File: tb/nand_mpc_seq_tb_top.sv
module nand_mpc_seq_tb_top;
    localparam int BW = 6, PW = 6, NB = 4, TW = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_onfi = 1'b0, cfg_poll = 1'b0;
    logic [TW-1:0] cfg_timeout = TW'(200);
    logic req_valid = 1'b0, req_last = 1'b0;
    logic [BW-1:0] req_blk_a = '0, req_blk_b = '0;
    logic [PW-1:0] req_page = '0;
    logic req_ready, wr_take, nf_cle, nf_ale, nf_we, nf_re, nf_rb;
    logic [7:0] wr_data, nf_dq_out, nf_dq_in;
    logic done_valid, done_final, done_prev_vld, done_prev_fail, done_cur_fail;
    logic err_pair, err_timeout;

    always #5 clk = ~clk;

    nand_mpc_seq #(.BLK_W(BW), .PAGE_W(PW), .NBYTES(NB), .TMO_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_onfi(cfg_onfi), .cfg_poll(cfg_poll),
        .cfg_timeout(cfg_timeout), .req_valid(req_valid), .req_ready(req_ready),
        .req_last(req_last), .req_blk_a(req_blk_a), .req_blk_b(req_blk_b),
        .req_page(req_page), .wr_take(wr_take), .wr_data(wr_data),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we(nf_we), .nf_re(nf_re),
        .nf_dq_out(nf_dq_out), .nf_dq_in(nf_dq_in), .nf_rb(nf_rb),
        .done_valid(done_valid), .done_final(done_final),
        .done_prev_vld(done_prev_vld), .done_prev_fail(done_prev_fail),
        .done_cur_fail(done_cur_fail), .err_pair(err_pair), .err_timeout(err_timeout));

    // Device model and bus monitor state (written only by the monitor).
    int n_log = 0, n_poll = 0, n_viol = 0, n_done = 0, n_errp = 0, n_errt = 0;
    int dcnt = 0, cyc = 0, busy = 0, arr = 0, pidx = 0, seen_id = 0;
    int t_sw = 0, t_err = 0;
    logic pfail_b = 1'b0, cfail_b = 1'b0;
    logic [9:0] dlog [0:63];
    logic [3:0] drec [0:7];
    // Controls written only by the stimulus.
    int chain_id = 0;
    logic hang = 1'b0;
    logic [7:0] pat = '0;
    int n_vec = 0, n_bad = 0;
    logic [9:0] elog [0:63];
    int ne = 0;

    assign nf_rb    = (busy == 0);
    assign nf_dq_in = {1'b1, nf_rb, (arr == 0), 3'b000, pfail_b, cfail_b};
    assign wr_data  = 8'(dcnt * 7 + 3);

    // Monitor and device model, updated away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (chain_id != seen_id) begin
            seen_id = chain_id; pidx = 0; busy = 0; arr = 0;
            n_log = 0; n_poll = 0; n_viol = 0; n_done = 0;
            pfail_b = 1'b0; cfail_b = 1'b0;
        end
        if (rst_n) begin
            if (nf_we) begin
                if (busy != 0 && !(nf_cle && nf_dq_out == 8'h70)) n_viol = n_viol + 1;
                if (nf_cle && nf_dq_out == 8'h70) n_poll = n_poll + 1;
                else begin
                    if (n_log < 64) dlog[n_log] = {nf_cle, nf_ale, nf_dq_out};
                    n_log = n_log + 1;
                end
            end
            if (wr_take) dcnt = dcnt + 1;
            if (done_valid) begin
                if (n_done < 8) drec[n_done] = {done_final, done_prev_vld, done_prev_fail, done_cur_fail};
                n_done = n_done + 1;
            end
            if (err_pair) n_errp = n_errp + 1;
            if (err_timeout) begin n_errt = n_errt + 1; t_err = cyc; end
            if (busy > 0 && !hang) busy = busy - 1;
            if (arr > 0 && !hang) arr = arr - 1;
            if (nf_we && nf_cle) begin
                if (nf_dq_out == 8'h11) begin busy = 3; t_sw = cyc; end
                if (nf_dq_out == 8'h15 || nf_dq_out == 8'h10) begin
                    busy = (nf_dq_out == 8'h15) ? 3 : 12;
                    arr = 12;
                    cfail_b = pat[pidx];
                    pfail_b = (pidx > 0) ? pat[pidx-1] : 1'b0;
                    pidx = pidx + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec = n_vec + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic c, input logic a, input logic [7:0] b);
        if (ne < 64) elog[ne] = {c, a, b};
        ne = ne + 1;
    endtask

    task automatic send(input logic [BW-1:0] a, input logic [BW-1:0] b,
                        input logic [PW-1:0] pg, input logic last);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_blk_a = a; req_blk_b = b; req_page = pg; req_last = last; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic new_chain();
        chain_id = chain_id + 1;
        @(negedge clk); @(negedge clk);
        ne = 0;
    endtask

    // Expected bytes for one page pair (R1, R2, R3), data counted from d0.
    task automatic expect_pair(input logic [BW-1:0] a, input logic [PW-1:0] pg,
                               input int d0, input logic onfi, input logic last);
        logic [11:0] wa, wb;
        wa = {a, pg}; wb = {a | BW'(1), pg};
        push(1, 0, 8'h80);
        push(0, 1, wa[7:0]); push(0, 1, {4'h0, wa[11:8]});
        for (int i = 0; i < NB; i++) push(0, 0, 8'((d0 + i) * 7 + 3));
        push(1, 0, 8'h11);
        push(1, 0, onfi ? 8'h80 : 8'h81);
        push(0, 1, wb[7:0]); push(0, 1, {4'h0, wb[11:8]});
        for (int i = 0; i < NB; i++) push(0, 0, 8'((d0 + NB + i) * 7 + 3));
        push(1, 0, last ? 8'h10 : 8'h15);
    endtask

    task automatic wait_done(input int target, input int errt0);
        while (n_done < target && n_errt == errt0) @(negedge clk);
    endtask

    task automatic check_log();
        chk(n_log == ne, "R1 byte count", n_log, ne);
        for (int i = 0; i < ne && i < 64; i++) begin
            if (elog[i][9] && (elog[i][7:0] == 8'h80 || elog[i][7:0] == 8'h81) && (i % 16) == 8)
                chk(dlog[i] == elog[i], "R2 second setup", dlog[i], elog[i]);
            else if ((i % 16) == 15)
                chk(dlog[i] == elog[i], "R3 confirm", dlog[i], elog[i]);
            else if (!elog[i][9] && !elog[i][8])
                chk(dlog[i] == elog[i], "R10 data byte", dlog[i], elog[i]);
            else
                chk(dlog[i] == elog[i], "R1 bus byte", dlog[i], elog[i]);
        end
    endtask

    task automatic run_chain(input logic onfi, input logic poll, input int len,
                             input logic [7:0] p, input int base);
        int d0;
        int errt0;
        cfg_onfi = onfi; cfg_poll = poll; pat = p;
        new_chain();
        errt0 = n_errt;
        d0 = dcnt;
        for (int k = 0; k < len; k++) begin
            logic [BW-1:0] a;
            logic [PW-1:0] pg;
            a  = BW'(((base + k) * 2) % 64);
            pg = PW'((base * 5 + k * 3) % 64);
            expect_pair(a, pg, d0 + k * 2 * NB, onfi, k == len - 1);
            send(a, a + BW'(1), pg, k == len - 1);
            wait_done(k + 1, errt0);
        end
        @(negedge clk); @(negedge clk);
        check_log();
        chk(n_done == len, "R7 result count", n_done, len);
        for (int k = 0; k < len && k < 8; k++) begin
            logic [3:0] ex;
            ex = {k == len - 1, k > 0, (k > 0) ? p[k-1] : 1'b0, (k == len - 1) ? p[k] : 1'b0};
            chk(drec[k] == ex, (k == len - 1) ? "R8 final result" : "R7 cache result", drec[k], ex);
        end
        if (poll) chk(n_poll > 2 * len, "R5 polling reads", n_poll, 2 * len + 1);
        else      chk(n_poll == 2 * len, "R5 pin-mode single read", n_poll, 2 * len);
        chk(n_viol == 0, "R6 no traffic while busy", n_viol, 0);
        chk(n_errt == errt0, "R9 no spurious timeout", n_errt, errt0);
    endtask

    task automatic run_timeout(input logic poll);
        int errt0;
        cfg_poll = poll; cfg_onfi = 1'b0; pat = '0;
        cfg_timeout = TW'(40);
        hang = 1'b1;
        new_chain();
        errt0 = n_errt;
        send(6'd10, 6'd11, 6'd2, 1'b0);
        for (int i = 0; i < 200 && n_errt == errt0; i++) @(negedge clk);
        chk(n_errt == errt0 + 1, "R9 timeout raised", n_errt, errt0 + 1);
        chk((t_err - t_sw) >= 40 && (t_err - t_sw) <= 44, "R9 timeout delay", t_err - t_sw, 42);
        chk(n_done == 0, "R9 no result on timeout", n_done, 0);
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 back to idle", req_ready, 1);
        hang = 1'b0;
        cfg_timeout = TW'(200);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1, "R11 reset ready", req_ready, 1);
        chk(nf_we == 1'b0 && nf_re == 1'b0, "R11 reset bus quiet", {nf_we, nf_re}, 0);
        chk(done_valid == 1'b0 && err_timeout == 1'b0 && err_pair == 1'b0,
            "R11 reset no pulses", {done_valid, err_timeout, err_pair}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: rejection from idle, odd block A and non-neighbour block B.
        begin
            int ep0;
            new_chain();
            ep0 = n_errp;
            send(6'd3, 6'd4, 6'd1, 1'b1);
            send(6'd4, 6'd7, 6'd1, 1'b1);
            repeat (3) @(negedge clk);
            chk(n_errp == ep0 + 2, "R4 rejections counted", n_errp, ep0 + 2);
            chk(n_log == 0 && n_poll == 0, "R4 no bus cycle", n_log + n_poll, 0);
            chk(req_ready == 1'b1, "R4 still idle", req_ready, 1);
        end

        // Near-exhaustive sweep: opcode variant x wait method x length x fail pattern.
        begin
            int base = 0;
            for (int onfi = 0; onfi < 2; onfi++)
                for (int poll = 0; poll < 2; poll++)
                    for (int len = 1; len <= 3; len++)
                        for (int p = 0; p < (1 << len); p++) begin
                            run_chain(onfi[0], poll[0], len, 8'(p), base);
                            base = (base + 1) % 30;
                        end
        end

        // R4: a rejection inside a chain keeps the chain alive.
        begin
            int ep0;
            cfg_onfi = 1'b1; cfg_poll = 1'b1; pat = 8'b01;
            new_chain();
            ep0 = n_errp;
            send(6'd20, 6'd21, 6'd5, 1'b0);
            wait_done(1, n_errt);
            send(6'd22, 6'd22, 6'd5, 1'b1);
            repeat (3) @(negedge clk);
            chk(n_errp == ep0 + 1, "R4 rejection in chain", n_errp, ep0 + 1);
            chk(req_ready == 1'b1, "R4 chain still open", req_ready, 1);
            send(6'd22, 6'd23, 6'd6, 1'b1);
            wait_done(2, n_errt);
            @(negedge clk);
            chk(n_done == 2, "R3 chain completes", n_done, 2);
            chk(drec[1] == 4'b1110, "R8 final after rejected request", drec[1], 4'b1110);
        end

        run_timeout(1'b1);
        run_timeout(1'b0);
        // After a timeout the next pair starts a fresh chain.
        run_chain(1'b0, 1'b1, 2, 8'b10, 7);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec + 1, n_bad + 1);
        $finish;
    end
endmodule